// File: doc/BRIEF.md
# Double-Buffer Bank Paging Decoder

This block steers memory traffic between two equally sized RAM banks, a primary bank and an alternate bank, which overlap in one 20 KB address window of an 8-bit processor's 64 KB space. A byte-wide control register sits at one I/O address. Software reads and writes it like any other location. One bit of the register chooses which bank the processor sees inside the window. A second, independent bit chooses which bank the display fetch engine reads from inside the same window.

Because the two bits are separate, software can render the next frame into one bank while the display scans out the other. At each frame boundary it swaps both bits with a read-modify-write. The block registers its bank enables and bank-relative addresses, so the RAM devices see them one clock after the request. The processor and the display each have their own request port.

Top module: `bank_pager`

## Requirements
- R1: A processor request with address 0x3000..0x7FFF enables the alternate bank when control bit 2 is 1, and the primary bank when control bit 2 is 0. Exactly one enable is raised.
- R2: A processor or display request with address 0x0000..0x2FFF always enables the primary bank, whatever the control bits are.
- R3: A request with address 0x8000 or above enables neither bank, for either requester.
- R4: A display request with address 0x3000..0x7FFF enables the alternate bank when control bit 0 is 1, and the primary bank when control bit 0 is 0.
- R5: Control bit 0 has no effect on processor bank selection, and control bit 2 has no effect on display bank selection.
- R6: A processor read of address 0xFE34 raises `cpu_rvalid` one cycle later and returns the whole control byte on `cpu_rdata`. An access to 0xFE34 enables no bank.
- R7: A write to 0xFE34 stores all eight data bits. Bits 1 and 3..7 read back exactly as written, even though they have no effect on selection.
- R8: After reset the control register holds 0x00, and all enables and `cpu_rvalid` are low.
- R9: A control write takes effect at the clock edge that samples it. A processor or display request in the very next cycle already uses the new value.
- R10: Bank enables and the bank-relative address (request address bits 14:0) appear one clock after the request is sampled. A cycle with no request leaves both enables of that requester low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access strobe |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Control register read data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after a register read |
| cpu_pri_ce | output | 1 | Processor enable for the primary bank |
| cpu_alt_ce | output | 1 | Processor enable for the alternate bank |
| cpu_ram_addr | output | 15 | Registered bank-relative processor address |
| vid_req | input | 1 | Display fetch strobe |
| vid_addr | input | 16 | Display fetch address |
| vid_pri_ce | output | 1 | Display enable for the primary bank |
| vid_alt_ce | output | 1 | Display enable for the alternate bank |
| vid_ram_addr | output | 15 | Registered bank-relative display address |

## Verification
All four settings of the two selection bits are written, and each setting is followed by a sweep of addresses on both ports. The sweep uses 0x0000, 0x2FFF, 0x3000, 0x5800, 0x7FFF, 0x8000 and 0xFFFF. The sweep separates the lower window edge from the upper one, and the window from plain RAM and from the space above RAM. Pairing every setting with both ports shows whether either bit leaks into the other requester's path. Writes whose unused bits are set, followed by the frame-swap read-modify-write sequence, show whether the full byte is kept and whether a request in the cycle right after a write already sees the new mapping.

// File: rtl/bank_pager_pkg.sv
package bank_pager_pkg;

  // Default geometry of the paged system
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int RAM_ADDR_W = 15;

  // Requester indices into the decode array
  localparam int NUM_REQ = 2;
  localparam int REQ_CPU = 0;
  localparam int REQ_VID = 1;

  // Registered result of one requester's bank decode
  typedef struct packed {
    logic                  pri_ce;
    logic                  alt_ce;
    logic [RAM_ADDR_W-1:0] ram_addr;
  } bank_sel_t;

endpackage

// File: rtl/bank_ctl_reg.sv
module bank_ctl_reg #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int unsigned REG_ADDR = 32'hFE34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              hit
);

  localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(REG_ADDR);

  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              wr_en;
  logic              rd_en;

  assign hit   = req && (addr == REG_A);
  assign wr_en = hit && we;
  assign rd_en = hit && !we;

  // Control byte: every bit is stored so that unused bits read back intact
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q <= wdata;
    end
  end

  // Registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) begin
        rdata_q <= ctl_q;
      end
    end
  end

  assign ctl    = ctl_q;
  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) $fell(rst) |-> (ctl_q == '0 && !rvalid_q)); // R8
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst) wr_en |=> (ctl_q == $past(wdata))); // R7
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (rst) rd_en |=> (rvalid_q && rdata_q == $past(ctl_q))); // R6
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !rd_en |=> !rvalid_q); // R6

endmodule

// File: rtl/bank_win_decode.sv
module bank_win_decode
  import bank_pager_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int unsigned WIN_LO  = 32'h3000,
  parameter int unsigned WIN_HI  = 32'h7FFF,
  parameter int unsigned RAM_TOP = 32'h8000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic          use_alt,
  output bank_sel_t     sel
);

  localparam logic [AW-1:0] LO_A  = AW'(WIN_LO);
  localparam logic [AW-1:0] HI_A  = AW'(WIN_HI);
  localparam logic [AW-1:0] TOP_A = AW'(RAM_TOP);

  logic      in_win;
  logic      in_ram;
  logic      pick_alt;
  bank_sel_t sel_d;
  bank_sel_t sel_q;

  assign in_win   = (addr >= LO_A) && (addr <= HI_A);
  assign in_ram   = (addr < TOP_A);
  assign pick_alt = in_win && use_alt;

  always_comb begin
    sel_d          = '0;
    sel_d.pri_ce   = req && in_ram && !pick_alt;
    sel_d.alt_ce   = req && pick_alt;
    sel_d.ram_addr = addr[RAM_ADDR_W-1:0];
  end

  // Registered enables and address, one cycle after the request
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign sel = sel_q;

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst) $onehot0({sel_q.pri_ce, sel_q.alt_ce})); // R1
  AST_LOW_PRIMARY: assert property (@(posedge clk) disable iff (rst) (req && addr < LO_A) |=> (sel_q.pri_ce && !sel_q.alt_ce)); // R2
  AST_HIGH_NONE: assert property (@(posedge clk) disable iff (rst) (req && addr >= TOP_A) |=> (!sel_q.pri_ce && !sel_q.alt_ce)); // R3
  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (rst) !req |=> (!sel_q.pri_ce && !sel_q.alt_ce)); // R10
  AST_ADDR_FOLLOWS: assert property (@(posedge clk) disable iff (rst) req |=> (sel_q.ram_addr == $past(addr[RAM_ADDR_W-1:0]))); // R10

endmodule

// File: rtl/bank_pager.sv
module bank_pager
  import bank_pager_pkg::*;
#(
  parameter int unsigned WIN_LO      = 32'h3000,
  parameter int unsigned WIN_HI      = 32'h7FFF,
  parameter int unsigned RAM_TOP     = 32'h8000,
  parameter int unsigned REG_ADDR    = 32'hFE34,
  parameter int          CPU_MAP_BIT = 2,
  parameter int          VID_MAP_BIT = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [DATA_W-1:0]     cpu_wdata,
  output logic [DATA_W-1:0]     cpu_rdata,
  output logic                  cpu_rvalid,
  output logic                  cpu_pri_ce,
  output logic                  cpu_alt_ce,
  output logic [RAM_ADDR_W-1:0] cpu_ram_addr,
  input  logic                  vid_req,
  input  logic [ADDR_W-1:0]     vid_addr,
  output logic                  vid_pri_ce,
  output logic                  vid_alt_ce,
  output logic [RAM_ADDR_W-1:0] vid_ram_addr
);

  logic [DATA_W-1:0] ctl;
  logic              reg_hit;
  logic              reg_wr;

  logic [NUM_REQ-1:0]             req_v;
  logic [NUM_REQ-1:0][ADDR_W-1:0] addr_v;
  logic [NUM_REQ-1:0]             alt_v;
  bank_sel_t                      sel_v [NUM_REQ];

  bank_ctl_reg #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR)
  ) ctl_i (
    .clk    (clk),
    .rst    (rst),
    .req    (cpu_req),
    .we     (cpu_we),
    .addr   (cpu_addr),
    .wdata  (cpu_wdata),
    .ctl    (ctl),
    .rdata  (cpu_rdata),
    .rvalid (cpu_rvalid),
    .hit    (reg_hit)
  );

  assign reg_wr = reg_hit && cpu_we;

  // Register accesses never reach a RAM bank
  assign req_v[REQ_CPU]  = cpu_req && !reg_hit;
  assign addr_v[REQ_CPU] = cpu_addr;
  assign alt_v[REQ_CPU]  = ctl[CPU_MAP_BIT];
  assign req_v[REQ_VID]  = vid_req;
  assign addr_v[REQ_VID] = vid_addr;
  assign alt_v[REQ_VID]  = ctl[VID_MAP_BIT];

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_path
    bank_win_decode #(
      .AW      (ADDR_W),
      .WIN_LO  (WIN_LO),
      .WIN_HI  (WIN_HI),
      .RAM_TOP (RAM_TOP)
    ) dec_i (
      .clk     (clk),
      .rst     (rst),
      .req     (req_v[g]),
      .addr    (addr_v[g]),
      .use_alt (alt_v[g]),
      .sel     (sel_v[g])
    );
  end

  assign cpu_pri_ce   = sel_v[REQ_CPU].pri_ce;
  assign cpu_alt_ce   = sel_v[REQ_CPU].alt_ce;
  assign cpu_ram_addr = sel_v[REQ_CPU].ram_addr;
  assign vid_pri_ce   = sel_v[REQ_VID].pri_ce;
  assign vid_alt_ce   = sel_v[REQ_VID].alt_ce;
  assign vid_ram_addr = sel_v[REQ_VID].ram_addr;

  AST_VID_BIT_KEPT: assert property (@(posedge clk) disable iff (rst) (reg_wr && cpu_wdata[VID_MAP_BIT] == ctl[VID_MAP_BIT]) |=> $stable(ctl[VID_MAP_BIT])); // R5
  AST_CPU_BIT_KEPT: assert property (@(posedge clk) disable iff (rst) (reg_wr && cpu_wdata[CPU_MAP_BIT] == ctl[CPU_MAP_BIT]) |=> $stable(ctl[CPU_MAP_BIT])); // R5
  AST_REG_NO_RAM: assert property (@(posedge clk) disable iff (rst) reg_hit |=> (!cpu_pri_ce && !cpu_alt_ce)); // R6

endmodule

// File: tb/bank_pager_tb_top.sv
`timescale 1ns/1ps
module bank_pager_tb_top;

  localparam int WATCHDOG_CYC = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;
  logic        cpu_pri_ce, cpu_alt_ce;
  logic [14:0] cpu_ram_addr;
  logic        vid_req = 1'b0;
  logic [15:0] vid_addr = '0;
  logic        vid_pri_ce, vid_alt_ce;
  logic [14:0] vid_ram_addr;

  always #2.5 clk = ~clk;

  bank_pager dut_i (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .cpu_pri_ce(cpu_pri_ce), .cpu_alt_ce(cpu_alt_ce), .cpu_ram_addr(cpu_ram_addr),
    .vid_req(vid_req), .vid_addr(vid_addr),
    .vid_pri_ce(vid_pri_ce), .vid_alt_ce(vid_alt_ce), .vid_ram_addr(vid_ram_addr)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected item: {pri, alt, ram_addr, rvalid, rdata}
  typedef struct packed {
    logic        pri;
    logic        alt;
    logic [14:0] ra;
    logic        rv;
    logic [7:0]  rd;
  } exp_t;

  exp_t  cpu_q[$];
  int    cpu_due[$];
  string cpu_tag[$];
  exp_t  vid_q[$];
  int    vid_due[$];
  string vid_tag[$];

  logic [7:0] mdl = 8'h00;

  function automatic bit in_win(input logic [15:0] a);
    return (a >= 16'h3000) && (a <= 16'h7FFF);
  endfunction

  function automatic string auto_tag(input logic [15:0] a, input bit vid);
    if (a >= 16'h8000) return "R3";
    if (a < 16'h3000) return "R2";
    return vid ? "R4" : "R1";
  endfunction

  task automatic check(input string tag, input string who, input exp_t act, input exp_t exp);
    exp_t a;
    a = act;
    if (!(exp.pri || exp.alt)) a.ra = exp.ra;
    if (!exp.rv) a.rd = exp.rd;
    total++;
    if (a !== exp) begin
      bad++;
      $display("FAIL %s %s: pri/alt/addr/rv/rd actual=%b/%b/%h/%b/%h expected=%b/%b/%h/%b/%h",
               tag, who, act.pri, act.alt, act.ra, act.rv, act.rd,
               exp.pri, exp.alt, exp.ra, exp.rv, exp.rd);
    end
  endtask

  // Driver: called at a falling edge, drives one cycle, pushes expectations
  task automatic step(input logic creq, input logic [15:0] ca, input logic cwe, input logic [7:0] cwd,
                      input logic vreq, input logic [15:0] va, input string ctag, input string vtag);
    exp_t ce, ve;
    bit   is_reg;
    cpu_req = creq; cpu_addr = ca; cpu_we = cwe; cpu_wdata = cwd;
    vid_req = vreq; vid_addr = va;
    is_reg = (ca == 16'hFE34);
    ce = '0;
    ce.ra = ca[14:0];
    if (creq && !is_reg) begin
      ce.alt = in_win(ca) && mdl[2];
      ce.pri = (ca < 16'h8000) && !ce.alt;
    end
    if (creq && is_reg && !cwe) begin
      ce.rv = 1'b1;
      ce.rd = mdl;
    end
    ve = '0;
    ve.ra = va[14:0];
    if (vreq) begin
      ve.alt = in_win(va) && mdl[0];
      ve.pri = (va < 16'h8000) && !ve.alt;
    end
    cpu_q.push_back(ce); cpu_due.push_back(cyc + 1);
    cpu_tag.push_back(ctag != "" ? ctag : (is_reg ? "R6" : (creq ? auto_tag(ca, 1'b0) : "R10")));
    vid_q.push_back(ve); vid_due.push_back(cyc + 1);
    vid_tag.push_back(vtag != "" ? vtag : (vreq ? auto_tag(va, 1'b1) : "R10"));
    if (creq && is_reg && cwe) mdl = cwd;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, 16'h0000, 1'b0, 8'h00, 1'b0, 16'h0000, "R10", "R10");
  endtask

  // Monitor: pops items that are due in the current cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      while (cpu_q.size() > 0 && cpu_due[0] <= cyc) begin
        exp_t act;
        act = '{pri: cpu_pri_ce, alt: cpu_alt_ce, ra: cpu_ram_addr, rv: cpu_rvalid, rd: cpu_rdata};
        if (cpu_due[0] < cyc) begin
          total++; bad++;
          $display("FAIL %s cpu: stale item actual=%0d expected=%0d", cpu_tag[0], cyc, cpu_due[0]);
        end else begin
          check(cpu_tag[0], "cpu", act, cpu_q[0]);
        end
        void'(cpu_q.pop_front()); void'(cpu_due.pop_front()); void'(cpu_tag.pop_front());
      end
      while (vid_q.size() > 0 && vid_due[0] <= cyc) begin
        exp_t act;
        act = '{pri: vid_pri_ce, alt: vid_alt_ce, ra: vid_ram_addr, rv: 1'b0, rd: 8'h00};
        if (vid_due[0] < cyc) begin
          total++; bad++;
          $display("FAIL %s vid: stale item actual=%0d expected=%0d", vid_tag[0], cyc, vid_due[0]);
        end else begin
          check(vid_tag[0], "vid", act, vid_q[0]);
        end
        void'(vid_q.pop_front()); void'(vid_due.pop_front()); void'(vid_tag.pop_front());
      end
    end
  end

  logic [15:0] sweep [7] = '{16'h0000, 16'h2FFF, 16'h3000, 16'h5800, 16'h7FFF, 16'h8000, 16'hFFFF};

  initial begin
    exp_t zero_e;
    logic [7:0] db;
    logic [7:0] cur;
    zero_e = '0;
    repeat (3) @(negedge clk);
    // R8: outputs low while reset is held
    check("R8", "cpu", '{pri: cpu_pri_ce, alt: cpu_alt_ce, ra: 15'h0, rv: cpu_rvalid, rd: 8'h00}, zero_e);
    check("R8", "vid", '{pri: vid_pri_ce, alt: vid_alt_ce, ra: 15'h0, rv: 1'b0, rd: 8'h00}, zero_e);
    rst = 1'b0;
    @(negedge clk);
    // R8: register reads 0x00 and window maps primary for both
    step(1'b1, 16'hFE34, 1'b0, 8'h00, 1'b1, 16'h5000, "R8", "R8");
    step(1'b1, 16'h4000, 1'b0, 8'h00, 1'b0, 16'h0000, "R8", "");
    idle();

    // Every combination of the two map bits, unused bits patterned (R7)
    for (int k = 0; k < 4; k++) begin
      logic [7:0] v;
      v = 8'hA2 ^ {3'b000, 3'(k) << 0, 2'b00} ;
      v = (8'hAA & 8'hFA) | (k[1] ? 8'h04 : 8'h00) | (k[0] ? 8'h01 : 8'h00);
      step(1'b1, 16'hFE34, 1'b1, v, 1'b0, 16'h0000, "R6", "");
      // R9: access right after the write uses the new mapping
      step(1'b1, 16'h3000, 1'b0, 8'h00, 1'b1, 16'h7FFF, "R9", "R9");
      step(1'b1, 16'hFE34, 1'b0, 8'h00, 1'b0, 16'h0000, "R7", "");
      for (int i = 0; i < 7; i++) begin
        // R5: both requesters swept together under each bit setting
        step(1'b1, sweep[i], 1'b0, 8'h00, 1'b1, sweep[6 - i], "", "");
        step(1'b1, sweep[i], 1'b1, 8'h5A, 1'b1, sweep[i], (in_win(sweep[i]) ? "R5" : ""), (in_win(sweep[i]) ? "R5" : ""));
      end
      idle();
    end

    // R7: all bits retained
    step(1'b1, 16'hFE34, 1'b1, 8'hFF, 1'b0, 16'h0000, "R7", "");
    step(1'b1, 16'hFE34, 1'b0, 8'h00, 1'b1, 16'h3000, "R7", "R4");
    step(1'b1, 16'hFE34, 1'b1, 8'h5A, 1'b0, 16'h0000, "R7", "");
    step(1'b1, 16'hFE34, 1'b0, 8'h00, 1'b1, 16'h6000, "R7", "R5");
    step(1'b1, 16'h6000, 1'b0, 8'h00, 1'b0, 16'h0000, "R5", "");

    // Frame-swap read-modify-write sequence
    db = 8'h01;
    for (int f = 0; f < 6; f++) begin
      cur = mdl;
      step(1'b1, 16'hFE34, 1'b0, 8'h00, 1'b1, 16'h3100, "R6", "R4");
      idle();
      step(1'b1, 16'hFE34, 1'b1, (cur & 8'hFA) | db, 1'b0, 16'h0000, "R7", "");
      step(1'b1, 16'h7FFF, 1'b1, 8'h11, 1'b1, 16'h3000, "R9", "R9");
      db = db ^ 8'h05;
    end

    // R10: idle cycles and display-only fetches
    idle();
    step(1'b0, 16'h4000, 1'b0, 8'h00, 1'b1, 16'h2000, "R10", "");
    idle();
    repeat (4) @(negedge clk);
    if (cpu_q.size() != 0 || vid_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R10 queue: pending actual=%0d expected=0", cpu_q.size() + vid_q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: cycles actual=%0d expected<%0d", cyc, WATCHDOG_CYC);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule